// File: doc/BRIEF.md
# Supervisor reset and watchdog generator

This block produces the active-low system reset for a processor domain. It combines three causes into one reset line. The first is power-up. The second is a supply-low flag that an analog comparator, outside the block, reports. The third is the expiry of a watchdog that software must keep restarting. Every duration is counted in pulses of a one-millisecond enable tick, which an external prescaler provides. All tick counts are parameters, so a simulation can use short values.

Software restarts the watchdog by pulling the shared chip-select/kick line from high to low. The line passes through a two-flop synchronizer before the falling edge is detected. A 2-bit setting from an external register picks one of three watchdog periods or switches the watchdog off. After every reset cause, the reset stays asserted for a fixed hold time. The block also reports which cause produced the most recent reset.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low` is 1 at a clock edge, `rst_out_n` is 0 after that edge and `cause` becomes 2'b10 (supply).
- R2: `rst_out_n` returns to 1 only after HOLD_TICKS ticks with `supply_low` at 0 and no watchdog expiry. A new supply-low cycle during the hold restarts the hold count from zero.
- R3: After `rst_n` is released, `rst_out_n` is 0 and `cause` is 2'b01 (power-up). Reset is released after HOLD_TICKS ticks, provided the supply is good.
- R4: `wd_sel` selects the watchdog period in ticks: 2'b00 gives WD_LONG_TICKS, 2'b01 gives WD_MID_TICKS, and 2'b10 gives WD_SHORT_TICKS.
- R5: `wd_sel` = 2'b11 disables the watchdog. No number of ticks then causes a watchdog reset.
- R6: A high-to-low transition of `kick_cs`, after two-flop synchronization, restarts the watchdog count. A rising edge does not restart it. A line held high or held low leads to a timeout.
- R7: When the watchdog count reaches the selected period, `rst_out_n` goes to 0 and `cause` becomes 2'b11 (watchdog). The reset is then held for HOLD_TICKS ticks.
- R8: The watchdog count is held at zero while reset is asserted. It starts from zero when reset is released.
- R9: A change of `wd_sel` restarts the watchdog count.
- R10: `cause` keeps its value while `rst_out_n` stays 1. It changes only when a new reset cause occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle timebase enable, one pulse per millisecond |
| supply_low | input | 1 | Comparator flag: supply below threshold |
| kick_cs | input | 1 | Chip-select/kick line; a falling edge restarts the watchdog |
| wd_sel | input | 2 | Watchdog period setting (00 long, 01 mid, 10 short, 11 off) |
| rst_out_n | output | 1 | System reset, active low |
| cause | output | 2 | Last reset cause (01 power-up, 10 supply, 11 watchdog) |

## Verification
The assertions check every cycle that a supply-low flag asserts reset on the next edge, and that a watchdog expiry asserts reset with the watchdog cause. They also check that release happens only on a tick with the supply good. Further checks confirm the watchdog stays silent while reset is held or while it is disabled, and that the cause does not change while reset is released. Only the bench scenarios can show the exact tick counts:

- the period chosen by each code,
- the hold length after each cause,
- that a rising edge of the kick line does not restart the count,
- that a change of the period setting restarts the count.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_POWER  = 2'b01,
        CAUSE_SUPPLY = 2'b10,
        CAUSE_WDOG   = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        WDSEL_LONG  = 2'b00,
        WDSEL_MID   = 2'b01,
        WDSEL_SHORT = 2'b10,
        WDSEL_OFF   = 2'b11
    } wdsel_e;

endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_raw,
    output logic kick_fall
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], kick_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign kick_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       kick_fall,
    input  logic [1:0] wd_sel,
    output logic       expire
);
    localparam int MAXP = (LONG_TICKS > MID_TICKS)
                        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                        : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
    localparam int CW = $clog2(MAXP + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
    } wd_state_t;

    wd_state_t st_d, st_q;
    logic [CW-1:0] last_d;

    always_comb begin
        st_d     = st_q;
        st_d.sel = wd_sel;
        expire   = 1'b0;
        case (wdsel_e'(st_q.sel))
            WDSEL_LONG:  last_d = CW'(LONG_TICKS - 1);
            WDSEL_MID:   last_d = CW'(MID_TICKS - 1);
            WDSEL_SHORT: last_d = CW'(SHORT_TICKS - 1);
            default:     last_d = '0;
        endcase
        if (hold || kick_fall || (wd_sel != st_q.sel) || (st_q.sel == WDSEL_OFF)) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == last_d) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, sel: WDSEL_OFF};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/supv_hold.sv
module supv_hold
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_low,
    input  logic       wd_expire,
    output logic       asserted,
    output logic [1:0] cause
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
        cause_e        why;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (supply_low) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.why    = CAUSE_SUPPLY;
        end else if (wd_expire) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.why    = CAUSE_WDOG;
        end else if (st_q.active && tick) begin
            if (st_q.cnt == HW'(HOLD_TICKS - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b1, cnt: '0, why: CAUSE_POWER};
        else        st_q <= st_d;
    end

    assign asserted = st_q.active;
    assign cause    = st_q.why;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int HOLD_TICKS     = 200,
    parameter int WD_LONG_TICKS  = 1400,
    parameter int WD_MID_TICKS   = 600,
    parameter int WD_SHORT_TICKS = 200,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       supply_low,
    input  logic       kick_cs,
    input  logic [1:0] wd_sel,
    output logic       rst_out_n,
    output logic [1:0] cause
);
    logic kick_fall;
    logic wd_expire;
    logic held;

    supv_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_raw  (kick_cs),
        .kick_fall (kick_fall)
    );

    supv_wdog #(
        .LONG_TICKS  (WD_LONG_TICKS),
        .MID_TICKS   (WD_MID_TICKS),
        .SHORT_TICKS (WD_SHORT_TICKS)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .hold      (held),
        .kick_fall (kick_fall),
        .wd_sel    (wd_sel),
        .expire    (wd_expire)
    );

    supv_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_ms),
        .supply_low (supply_low),
        .wd_expire  (wd_expire),
        .asserted   (held),
        .cause      (cause)
    );

    assign rst_out_n = ~held;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       supply_low,
    input logic [1:0] wd_sel,
    input logic       rst_out_n,
    input logic [1:0] cause,
    input logic       wd_expire
);
    // R1
    assert_supply_low_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!rst_out_n && cause == 2'b10));

    // R2
    assert_release_on_good_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tick_ms) && !$past(supply_low) && !$past(wd_expire)));

    // R7
    assert_expiry_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && !supply_low) |=> (!rst_out_n && cause == 2'b11));

    // R8
    assert_wdog_quiet_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> !wd_expire);

    // R5
    assert_wdog_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == 2'b11) |-> !wd_expire);

    // R10
    assert_cause_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && $past(rst_out_n)) |-> $stable(cause));

    // R3
    assert_cause_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cause != 2'b00);
endmodule

bind supv_reset_gen supv_reset_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .supply_low (supply_low),
    .wd_sel     (wd_sel),
    .rst_out_n  (rst_out_n),
    .cause      (cause),
    .wd_expire  (wd_expire)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
    localparam int HOLD  = 4;
    localparam int LONG  = 10;
    localparam int MID   = 6;
    localparam int SHORT = 3;

    localparam logic [1:0] SEL_TAB [3] = '{2'b00, 2'b01, 2'b10};
    localparam int         PER_TAB [3] = '{LONG, MID, SHORT};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       supply_low = 1'b0;
    logic       kick_cs = 1'b1;
    logic [1:0] wd_sel = 2'b11;
    logic       rst_out_n;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supv_reset_gen #(
        .HOLD_TICKS     (HOLD),
        .WD_LONG_TICKS  (LONG),
        .WD_MID_TICKS   (MID),
        .WD_SHORT_TICKS (SHORT)
    ) u_supv_reset_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .supply_low (supply_low),
        .kick_cs    (kick_cs),
        .wd_sel     (wd_sel),
        .rst_out_n  (rst_out_n),
        .cause      (cause)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic set_kick(input logic v);
        @(negedge clk) kick_cs = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_sel(input logic [1:0] v);
        @(negedge clk) wd_sel = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset level", {1'b0, rst_out_n}, 2'd0);
        chk("R3 power cause", cause, 2'b01);
        ticks(HOLD - 1);
        chk("R3 still held", {1'b0, rst_out_n}, 2'd0);
        ticks(1);
        chk("R3 released", {1'b0, rst_out_n}, 2'd1);

        // R4 / R7: period table
        for (int i = 0; i < 3; i++) begin
            set_sel(SEL_TAB[i]);
            ticks(PER_TAB[i] - 1);
            chk("R4 before period", {1'b0, rst_out_n}, 2'd1);
            ticks(1);
            chk("R4 at period", {1'b0, rst_out_n}, 2'd0);
            chk("R7 watchdog cause", cause, 2'b11);
            ticks(HOLD - 1);
            chk("R7 held", {1'b0, rst_out_n}, 2'd0);
            ticks(1);
            chk("R7 released", {1'b0, rst_out_n}, 2'd1);
        end

        // R6: falling edge restarts, rising edge does not
        set_sel(2'b01);
        ticks(MID - 1);
        set_kick(1'b0);
        ticks(MID - 1);
        chk("R6 fall restarts", {1'b0, rst_out_n}, 2'd1);
        set_kick(1'b1);
        ticks(1);
        chk("R6 rise ignored", {1'b0, rst_out_n}, 2'd0);
        ticks(HOLD);
        chk("R7 release after kick test", {1'b0, rst_out_n}, 2'd1);

        // R8: count starts from zero at release, kick held high
        ticks(MID - 1);
        chk("R8 fresh count", {1'b0, rst_out_n}, 2'd1);
        ticks(1);
        chk("R8 timeout from zero", {1'b0, rst_out_n}, 2'd0);
        ticks(HOLD);

        // R9: setting change restarts
        ticks(MID - 1);
        set_sel(2'b00);
        ticks(LONG - 1);
        chk("R9 restart on change", {1'b0, rst_out_n}, 2'd1);
        ticks(1);
        chk("R9 long timeout", {1'b0, rst_out_n}, 2'd0);
        ticks(HOLD);

        // R5 / R10: disabled watchdog, cause held
        set_sel(2'b11);
        ticks(3 * LONG);
        chk("R5 disabled", {1'b0, rst_out_n}, 2'd1);
        chk("R10 cause held", cause, 2'b11);

        // R1 / R2: supply low
        @(negedge clk) supply_low = 1'b1;
        @(negedge clk);
        chk("R1 supply reset", {1'b0, rst_out_n}, 2'd0);
        chk("R1 supply cause", cause, 2'b10);
        ticks(HOLD + 2);
        chk("R2 held while low", {1'b0, rst_out_n}, 2'd0);
        @(negedge clk) supply_low = 1'b0;
        ticks(HOLD - 1);
        @(negedge clk) supply_low = 1'b1;
        @(negedge clk) supply_low = 1'b0;
        ticks(HOLD - 1);
        chk("R2 hold restarted", {1'b0, rst_out_n}, 2'd0);
        ticks(1);
        chk("R2 released", {1'b0, rst_out_n}, 2'd1);
        chk("R10 supply cause kept", cause, 2'b10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule